// File: doc/BRIEF.md
# Variable-Slot In-Order Retire Queue

The block keeps program order for instructions that finish out of order. It is a circular buffer of `DEPTH` retire slots. At dispatch, an instruction asks for room by giving its micro-op count. It takes a run of consecutive slots and gets back a token, which is the index of the first slot of that run. When the instruction finishes, the execution side returns the token, and the entry is marked as done.

On every clock the block looks at the oldest entries. It retires, in order, those already marked done. It stops at the first entry that is not done, or when it reaches the per-cycle limit. Each retired entry puts its instruction index on a retire lane, with lane 0 holding the oldest. The head pointer then moves past the slots of each retired entry, and those slots return to the free pool.

An entry uses as many slots as its micro-op count, clamped to at least one and at most `DEPTH`. So an instruction with no micro-ops still holds a place in order. `DEPTH` must be a power of two.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty. All `DEPTH` slots are free, the token output is 0, no retire lane is valid, and a request of `DEPTH` micro-ops is reported as acceptable.
- R2: The number of slots an entry takes is its micro-op count when that count lies between 1 and `DEPTH`.
- R3: The token output always shows the current tail slot. An accepted reservation advances it by the entry's slot count, modulo `DEPTH`, from the next cycle.
- R4: `rsv_ready_o` is 1 exactly when the clamped slot count of `rsv_uops_i` is no more than the free slot count. A request made while `rsv_ready_o` is 0 changes nothing.
- R5: A done notification on `exe_token_i` makes that entry eligible to retire from the next cycle. An entry is never retired before it is marked done. Notifications are legal only for an occupied, not-yet-done token.
- R6: Retirement is strictly in order. A done entry behind an entry that is not done is held back. Valid lanes always form a contiguous group starting at lane 0.
- R7: At most `ret_limit_i` entries retire per cycle. A limit of 0 allows up to `LANES` entries.
- R8: A retire lane shows the stored instruction index of its entry. Lane 0 holds the oldest entry. Retiring an entry returns all of its slots to the free count and moves the head past them. An empty queue retires nothing.
- R9: A request with a micro-op count of 0 takes exactly one slot.
- R10: A micro-op count above `DEPTH` is clamped to `DEPTH`. Such an entry is accepted only into an empty queue, and it fills the queue completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Reservation request |
| rsv_idx_i | input | IDX_W | Instruction index to store |
| rsv_uops_i | input | UOP_W | Micro-op count of the request |
| rsv_ready_o | output | 1 | Request fits in the free slots |
| rsv_token_o | output | PTR_W | Token given to an accepted request (current tail) |
| exe_valid_i | input | 1 | Execution-complete notification |
| exe_token_i | input | PTR_W | Token of the completed entry |
| ret_limit_i | input | LIM_W | Per-cycle retire limit, 0 means `LANES` |
| ret_valid_o | output | LANES | Retire lane valid, lane 0 oldest |
| ret_idx_o | output | LANES x IDX_W | Instruction index per retire lane |

## Verification
The case that is hardest to reach from the ports is a young entry that is already done sitting behind an older entry that is not, while multi-slot entries wrap past the end of the buffer. That case needs the tail already near the top index, and completions arriving in reverse order. The stimulus first uses directed youngest-first completions and an oversize entry that takes the whole buffer. It then runs a long mixed sequence with micro-op counts beyond `DEPTH`, random completion order and changing retire limits. A behavioural queue model predicts the ready flag, the token and every retire lane on each cycle.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // clamp a micro-op count into a legal slot count
  function automatic int rq_slots(int uops, int depth);
    if (uops < 1) return 1;
    if (uops > depth) return depth;
    return uops;
  endfunction
endpackage

// File: rtl/rq_slot_calc.sv
module rq_slot_calc #(
  parameter int UOP_W = 5,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic [UOP_W-1:0] uops_i,
  output logic [CNT_W-1:0] slots_o
);
  always_comb slots_o = CNT_W'(rq_pkg::rq_slots(int'({1'b0, uops_i}), DEPTH));
endmodule

// File: rtl/rq_retire_walk.sv
module rq_retire_walk #(
  parameter int DEPTH = 16,
  parameter int LANES = 3,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5,
  parameter int LIM_W = 2
) (
  input  logic [PTR_W-1:0]            head_i,
  input  logic [CNT_W-1:0]            free_i,
  input  logic [LIM_W-1:0]            limit_i,
  input  logic [DEPTH-1:0]            used_i,
  input  logic [DEPTH-1:0]            done_i,
  input  logic [DEPTH-1:0][CNT_W-1:0] cnt_i,
  output logic [LANES-1:0]            valid_o,
  output logic [LANES-1:0][PTR_W-1:0] slot_o,
  output logic [CNT_W-1:0]            freed_o,
  output logic [PTR_W-1:0]            head_o
);
  logic [PTR_W-1:0] p;
  logic [CNT_W-1:0] fr;
  logic             run;
  int               cap;

  always_comb begin
    p   = head_i;
    fr  = '0;
    run = 1'b1;
    cap = (limit_i == '0) ? LANES : int'({1'b0, limit_i});
    for (int k = 0; k < LANES; k++) begin
      slot_o[k]  = p;
      valid_o[k] = run && (k < cap)
                   && (({1'b0, free_i} + {1'b0, fr}) < (CNT_W+1)'(DEPTH))
                   && used_i[p] && done_i[p];
      if (valid_o[k]) begin
        fr = fr + cnt_i[p];
        p  = p + cnt_i[p][PTR_W-1:0];
      end else begin
        run = 1'b0;
      end
    end
    freed_o = fr;
    head_o  = p;
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH = 16,
  parameter int LANES = 3,
  parameter int IDX_W = 8,
  parameter int UOP_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int LIM_W = $clog2(LANES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rsv_valid_i,
  input  logic [IDX_W-1:0]           rsv_idx_i,
  input  logic [UOP_W-1:0]           rsv_uops_i,
  output logic                       rsv_ready_o,
  output logic [PTR_W-1:0]           rsv_token_o,
  input  logic                       exe_valid_i,
  input  logic [PTR_W-1:0]           exe_token_i,
  input  logic [LIM_W-1:0]           ret_limit_i,
  output logic [LANES-1:0]           ret_valid_o,
  output logic [LANES-1:0][IDX_W-1:0] ret_idx_o
);
  logic [DEPTH-1:0]            used_q, done_q;
  logic [DEPTH-1:0][CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0][IDX_W-1:0] idx_q;
  logic [PTR_W-1:0]            head_q, tail_q, head_nxt;
  logic [CNT_W-1:0]            free_q, freed, slots;
  logic [LANES-1:0][PTR_W-1:0] ret_slot;
  logic                        fire;

  rq_slot_calc #(.UOP_W(UOP_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_calc (
    .uops_i (rsv_uops_i),
    .slots_o(slots)
  );

  rq_retire_walk #(
    .DEPTH(DEPTH), .LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W), .LIM_W(LIM_W)
  ) u_walk (
    .head_i (head_q),
    .free_i (free_q),
    .limit_i(ret_limit_i),
    .used_i (used_q),
    .done_i (done_q),
    .cnt_i  (cnt_q),
    .valid_o(ret_valid_o),
    .slot_o (ret_slot),
    .freed_o(freed),
    .head_o (head_nxt)
  );

  assign rsv_ready_o = (slots <= free_q);
  assign rsv_token_o = tail_q;
  assign fire        = rsv_valid_i && rsv_ready_o;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ret_idx_o[g] = idx_q[ret_slot[g]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      done_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (ret_valid_o[k]) begin
          used_q[ret_slot[k]] <= 1'b0;
          done_q[ret_slot[k]] <= 1'b0;
        end
      end
      if (fire) begin
        used_q[tail_q] <= 1'b1;
        done_q[tail_q] <= 1'b0;
        cnt_q[tail_q]  <= slots;
        idx_q[tail_q]  <= rsv_idx_i;
        tail_q         <= tail_q + slots[PTR_W-1:0];
      end
      if (exe_valid_i) done_q[exe_token_i] <= 1'b1;
      head_q <= head_nxt;
      free_q <= free_q - (fire ? slots : '0) + freed;
    end
  end
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int DEPTH = 16,
  parameter int LANES = 3,
  parameter int UOP_W = 5,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5,
  parameter int LIM_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rsv_valid_i,
  input logic [UOP_W-1:0] rsv_uops_i,
  input logic             rsv_ready_o,
  input logic [PTR_W-1:0] rsv_token_o,
  input logic             exe_valid_i,
  input logic [PTR_W-1:0] exe_token_i,
  input logic [LIM_W-1:0] ret_limit_i,
  input logic [LANES-1:0] ret_valid_o,
  input logic [DEPTH-1:0] used_q,
  input logic [DEPTH-1:0] done_q,
  input logic [CNT_W-1:0] free_q
);
  logic [CNT_W-1:0] want;
  always_comb begin
    if ({1'b0, rsv_uops_i} > (UOP_W+1)'(DEPTH)) want = CNT_W'(DEPTH);
    else if (rsv_uops_i == '0)                  want = CNT_W'(1);
    else                                        want = CNT_W'(rsv_uops_i);
  end

  a_r3_token_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_valid_i && rsv_ready_o) |=>
      rsv_token_o == PTR_W'($past(rsv_token_o) + $past(want)));

  a_r4_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_q == '0) |-> !rsv_ready_o);

  a_r5_exe_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_valid_i |-> (used_q[exe_token_i] && !done_q[exe_token_i]));

  a_r6_lanes_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(LANES'(ret_valid_o + 1'b1)));

  a_r7_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_limit_i != '0) |-> ($countones(ret_valid_o) <= int'({1'b0, ret_limit_i})));

  a_r8_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_q == CNT_W'(DEPTH)) |-> (ret_valid_o == '0));
endmodule

bind retire_queue rq_checker #(
  .DEPTH(DEPTH), .LANES(LANES), .UOP_W(UOP_W),
  .PTR_W(PTR_W), .CNT_W(CNT_W), .LIM_W(LIM_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rsv_valid_i(rsv_valid_i),
  .rsv_uops_i (rsv_uops_i),
  .rsv_ready_o(rsv_ready_o),
  .rsv_token_o(rsv_token_o),
  .exe_valid_i(exe_valid_i),
  .exe_token_i(exe_token_i),
  .ret_limit_i(ret_limit_i),
  .ret_valid_o(ret_valid_o),
  .used_q     (used_q),
  .done_q     (done_q),
  .free_q     (free_q)
);

// File: tb/tb_retire_queue.sv
module tb_retire_queue;
  localparam int DEPTH = 16;
  localparam int LANES = 3;
  localparam int IDX_W = 8;
  localparam int UOP_W = 5;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LIM_W = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rsv_valid_i = 1'b0;
  logic [IDX_W-1:0] rsv_idx_i = '0;
  logic [UOP_W-1:0] rsv_uops_i = '0;
  logic rsv_ready_o;
  logic [PTR_W-1:0] rsv_token_o;
  logic exe_valid_i = 1'b0;
  logic [PTR_W-1:0] exe_token_i = '0;
  logic [LIM_W-1:0] ret_limit_i = '0;
  logic [LANES-1:0] ret_valid_o;
  logic [LANES-1:0][IDX_W-1:0] ret_idx_o;

  always #5 clk = ~clk;

  retire_queue #(.DEPTH(DEPTH), .LANES(LANES), .IDX_W(IDX_W), .UOP_W(UOP_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rsv_valid_i(rsv_valid_i), .rsv_idx_i(rsv_idx_i), .rsv_uops_i(rsv_uops_i),
    .rsv_ready_o(rsv_ready_o), .rsv_token_o(rsv_token_o),
    .exe_valid_i(exe_valid_i), .exe_token_i(exe_token_i),
    .ret_limit_i(ret_limit_i), .ret_valid_o(ret_valid_o), .ret_idx_o(ret_idx_o)
  );

  int n_cmp = 0, n_bad = 0;
  int m_idx[$], m_slots[$], m_tok[$];
  bit m_done[$];
  int m_tail = 0, m_free = DEPTH, exp_n = 0, exe_pos = -1;
  bit finished = 0;

  function automatic int slots_of(int u);
    if (u < 1) return 1;
    if (u > DEPTH) return DEPTH;
    return u;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int lim;
    bit er;
    er = slots_of(int'(rsv_uops_i)) <= m_free;
    chk(rsv_ready_o == er, "R4 ready", int'(rsv_ready_o), int'(er));
    chk(int'(rsv_token_o) == m_tail, "R3 token", int'(rsv_token_o), m_tail);
    lim = (ret_limit_i == 0) ? LANES : int'(ret_limit_i);
    exp_n = 0;
    while (exp_n < lim && exp_n < m_idx.size() && m_done[exp_n]) exp_n++;
    for (int k = 0; k < LANES; k++) begin
      chk(ret_valid_o[k] == (k < exp_n), "R5 R6 R7 retire valid",
          int'(ret_valid_o[k]), int'(k < exp_n));
      if (k < exp_n)
        chk(int'(ret_idx_o[k]) == m_idx[k], "R8 retire index", int'(ret_idx_o[k]), m_idx[k]);
    end
  endtask

  // emode: 0 none, 1 random pending, 2 youngest pending, 3 oldest pending
  task automatic cyc(bit rv, int ridx, int ru, int emode, int lim);
    int pend[$];
    bit fire;
    int s;
    rsv_valid_i = rv;
    rsv_idx_i   = IDX_W'(ridx);
    rsv_uops_i  = UOP_W'(ru);
    ret_limit_i = LIM_W'(lim);
    for (int i = 0; i < m_idx.size(); i++) if (!m_done[i]) pend.push_back(i);
    exe_pos = -1;
    if (pend.size() > 0) begin
      if (emode == 1) exe_pos = pend[$urandom_range(pend.size() - 1)];
      else if (emode == 2) exe_pos = pend[pend.size() - 1];
      else if (emode == 3) exe_pos = pend[0];
    end
    exe_valid_i = (exe_pos >= 0);
    exe_token_i = (exe_pos >= 0) ? PTR_W'(m_tok[exe_pos]) : '0;
    #1 compare();
    s = slots_of(ru);
    fire = rv && (s <= m_free);
    @(posedge clk);
    if (exe_pos >= 0) m_done[exe_pos] = 1'b1;
    for (int i = 0; i < exp_n; i++) begin
      m_free += m_slots[0];
      void'(m_idx.pop_front()); void'(m_slots.pop_front());
      void'(m_tok.pop_front()); void'(m_done.pop_front());
    end
    if (fire) begin
      m_idx.push_back(ridx % (1 << IDX_W)); m_slots.push_back(s);
      m_tok.push_back(m_tail); m_done.push_back(1'b0);
      m_tail = (m_tail + s) % DEPTH;
      m_free -= s;
    end
    @(negedge clk);
  endtask

  task automatic quiet(int u);
    rsv_valid_i = 1'b0; exe_valid_i = 1'b0; rsv_uops_i = UOP_W'(u);
    #1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    quiet(DEPTH);
    chk(rsv_ready_o == 1'b1, "R1 ready after reset", int'(rsv_ready_o), 1);
    chk(rsv_token_o == 0, "R1 token after reset", int'(rsv_token_o), 0);
    chk(ret_valid_o == 0, "R1 no retire after reset", int'(ret_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: zero-op entries take one slot each
    for (int i = 0; i < 3; i++) cyc(1, 10 + i, 0, 0, 0);
    quiet(0);
    chk(rsv_token_o == 3, "R9 zero-op slot", int'(rsv_token_o), 3);

    // R6: youngest completes first, nothing may retire
    cyc(0, 0, 0, 2, 0);
    cyc(0, 0, 0, 2, 0);
    quiet(0);
    chk(ret_valid_o == 0, "R6 held behind oldest", int'(ret_valid_o), 0);
    cyc(0, 0, 0, 3, 0);
    quiet(0);
    chk($countones(ret_valid_o) == 3, "R7 zero limit retires all lanes",
        $countones(ret_valid_o), 3);
    cyc(0, 0, 0, 0, 0);

    // R2: five micro-ops take five slots
    cyc(1, 20, 5, 0, 0);
    quiet(0);
    chk(rsv_token_o == 8, "R2 five slots", int'(rsv_token_o), 8);
    cyc(0, 0, 0, 3, 0);
    cyc(0, 0, 0, 0, 0);

    // R10: oversize entry fills the whole queue
    cyc(1, 50, 31, 0, 0);
    quiet(0);
    chk(rsv_ready_o == 1'b0, "R10 full after oversize", int'(rsv_ready_o), 0);
    chk(rsv_token_o == 8, "R10 tail wraps to itself", int'(rsv_token_o), 8);
    cyc(1, 51, 0, 3, 0);
    cyc(0, 0, 0, 0, 0);
    quiet(DEPTH);
    chk(rsv_ready_o == 1'b1, "R8 slots returned", int'(rsv_ready_o), 1);

    // R7: limit of one
    for (int i = 0; i < 3; i++) cyc(1, 60 + i, 1, 0, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 3, 1);
    quiet(0);
    chk($countones(ret_valid_o) <= 1, "R7 limit one", $countones(ret_valid_o), 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1);

    // mixed traffic
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 3) != 0, int'($urandom % 256), int'($urandom % 20),
          ($urandom % 3 != 0) ? 1 : 0, int'($urandom % 4));
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule